// File: doc/BRIEF.md
# Paired-Instruction Accumulator Processor

This block is a multi-cycle processor core for a word-addressed accumulator machine. Each 40-bit memory word carries two 20-bit instructions, and each instruction is an 8-bit opcode followed by a 12-bit address. The core fetches a word and runs its left instruction. It keeps the right instruction in an instruction buffer and runs it next, then fetches the following word. Data words are 40-bit sign-magnitude numbers. The core updates an accumulator (AC) and a multiplier/quotient register (MQ) through loads, additions, subtractions, multiply, divide and one-bit shifts. Jumps can land on either half of a target word. Partial stores overwrite only one 12-bit address field of a word, which lets a program patch its own instructions.

The 1000-word single-port synchronous memory sits inside the block. A host port shares that memory port while the core is idle or halted. The host uses it to write the program and data, and later to read back results. A start pulse sets the program counter to zero and empties the instruction buffer. Execution then runs until a halt instruction or an error. After that, halted stays high, together with at most one error flag.

Top module: `acc_pair_cpu`

## Requirements
- R1: After reset, halted, err_addr, err_div and err_ill are 0 and AC and MQ are 0. A start pulse begins execution at word 0. In every fetched word the left instruction runs before the right one.
- R2: Word layout (bit 39 is most significant). The left instruction is bits 39:20, with its opcode in 39:32 and its address in 31:20. The right instruction has its opcode in 19:12 and its address in 11:0. For data, bit 39 is the sign (1 = negative) and bits 38:0 are the magnitude. A result with zero magnitude is always written to AC or MQ as +0.
- R3: Opcode 0x01 loads M(X) into AC, 0x02 loads -M(X), 0x03 loads |M(X)| and 0x04 loads -|M(X)|. Opcode 0x09 loads M(X) into MQ, and 0x0A copies MQ into AC.
- R4: Opcodes 0x05, 0x06, 0x07 and 0x08 set AC to AC+M(X), AC-M(X), AC+|M(X)| and AC-|M(X)| in signed arithmetic. The result magnitude is taken modulo 2^39.
- R5: Opcode 0x0B (MUL) forms MQ × M(X). The upper 39 magnitude bits of the 78-bit product go to AC and the lower 39 bits go to MQ. Both take the product's sign.
- R6: Opcode 0x0C (DIV) divides AC by M(X). MQ gets the quotient, truncated toward zero. AC gets the remainder, which carries the dividend's sign. A divisor of zero magnitude leaves AC and MQ unchanged, sets err_div and halts.
- R7: Opcode 0x0D continues at the left instruction of word X. Opcode 0x0E continues at the right instruction of word X, and the left half of that word is not executed. In both cases the buffered right instruction of the current word is discarded.
- R8: Opcodes 0x0F and 0x10 jump like 0x0D and 0x0E only when the AC sign bit is 0. Otherwise execution continues with the next instruction.
- R9: Opcode 0x21 writes AC to word X. Opcode 0x12 replaces only bits 31:20 of word X with AC bits 11:0. Opcode 0x13 replaces only bits 11:0 of word X with AC bits 11:0.
- R10: Opcode 0x14 shifts the AC magnitude left by one bit and drops its top bit. Opcode 0x15 shifts it right by one bit. Both keep the sign and ignore the address field, including address values of 1000 or more.
- R11: Opcode 0x00 sets halted with no error flag. The core stays halted until the next start pulse. Start clears halted and all error flags.
- R12: If a memory-using instruction has an address of 1000 or more, or a fetch is made at PC of 1000 or more, the core sets err_addr and halts without writing memory.
- R13: Any opcode not listed in R3 to R11 sets err_ill and halts.
- R14: While the core is idle or halted, host_we writes host_wdata to host_addr. host_rdata shows the word at host_addr one clock after host_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse: PC to 0, buffer emptied, run |
| host_we | input | 1 | Host memory write enable (idle/halted only) |
| host_addr | input | 12 | Host memory address |
| host_wdata | input | 40 | Host write data |
| host_rdata | output | 40 | Memory read data, one cycle after address |
| halted | output | 1 | Core has stopped |
| err_addr | output | 1 | Address at or above 1000 was used |
| err_div | output | 1 | Divide by zero |
| err_ill | output | 1 | Undefined opcode |
| ac_out | output | 40 | Accumulator |
| mq_out | output | 40 | Multiplier/quotient register |

## Verification
The bench runs a behavioural interpreter of the instruction set beside the core. After each program it compares AC, MQ, the flags and all 1000 words. The programs target the following cases:
- Negative zero in data and after a right shift: a core that failed to normalise it would leave a sign bit set on a zero AC.
- A sum that exceeds 39 bits of magnitude: a core that kept a carry bit would give a wrong wrapped value.
- Jumps to a right half: a core that ran the skipped left half, or the discarded buffered instruction, would leave extra stores in memory.
- Partial stores over patterned words: a core that wrote the wrong field would damage neighbouring bits.
- Shifts with out-of-range address fields: a core that checked their address would raise a spurious err_addr.
- A divide by negative zero, a store to address 1000, a run off the end of memory and an undefined opcode: a core that got any of these wrong would change registers or memory, or raise the wrong flag.

// File: rtl/acc_pair_pkg.sv
// Shared constants for the paired-instruction accumulator core.
// Assumes a 40-bit word holding two 20-bit instructions (8-bit opcode,
// 12-bit address) and sign-magnitude data with the sign in the top bit.
package acc_pair_pkg;
    localparam int WORD_W = 40;
    localparam int HALF_W = WORD_W / 2;
    localparam int OP_W   = 8;
    localparam int ADDR_W = HALF_W - OP_W;

    localparam logic [OP_W-1:0] OPC_HALT   = 8'h00;
    localparam logic [OP_W-1:0] OPC_LD     = 8'h01;
    localparam logic [OP_W-1:0] OPC_LDNEG  = 8'h02;
    localparam logic [OP_W-1:0] OPC_LDABS  = 8'h03;
    localparam logic [OP_W-1:0] OPC_LDNABS = 8'h04;
    localparam logic [OP_W-1:0] OPC_ADD    = 8'h05;
    localparam logic [OP_W-1:0] OPC_SUB    = 8'h06;
    localparam logic [OP_W-1:0] OPC_ADDABS = 8'h07;
    localparam logic [OP_W-1:0] OPC_SUBABS = 8'h08;
    localparam logic [OP_W-1:0] OPC_LDMQ   = 8'h09;
    localparam logic [OP_W-1:0] OPC_MQ2AC  = 8'h0A;
    localparam logic [OP_W-1:0] OPC_MUL    = 8'h0B;
    localparam logic [OP_W-1:0] OPC_DIV    = 8'h0C;
    localparam logic [OP_W-1:0] OPC_JL     = 8'h0D;
    localparam logic [OP_W-1:0] OPC_JR     = 8'h0E;
    localparam logic [OP_W-1:0] OPC_JPL    = 8'h0F;
    localparam logic [OP_W-1:0] OPC_JPR    = 8'h10;
    localparam logic [OP_W-1:0] OPC_STFL   = 8'h12;
    localparam logic [OP_W-1:0] OPC_STFR   = 8'h13;
    localparam logic [OP_W-1:0] OPC_SHL    = 8'h14;
    localparam logic [OP_W-1:0] OPC_SHR    = 8'h15;
    localparam logic [OP_W-1:0] OPC_ST     = 8'h21;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_FWAIT, S_SPLIT, S_DECODE,
        S_DWAIT, S_EXEC, S_NEXT, S_HALT
    } core_state_e;

    // True for every defined opcode.
    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return (op <= OPC_JPR) || (op >= OPC_STFL && op <= OPC_SHR) || (op == OPC_ST);
    endfunction

    // True for opcodes whose address field names a memory word.
    function automatic logic op_uses_mem(input logic [OP_W-1:0] op);
        return op_legal(op) && !(op == OPC_HALT || op == OPC_MQ2AC ||
                                 op == OPC_SHL || op == OPC_SHR);
    endfunction
endpackage

// File: rtl/acc_pair_mem.sv
// Single-port synchronous word memory. One read or write per cycle;
// read data is registered. Addresses at or beyond DEPTH are not written
// and read back as zero.
module acc_pair_mem #(
    parameter int DEPTH  = 1000,
    parameter int ADDR_W = 12,
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [0:DEPTH-1];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = addr < ADDR_W'(DEPTH);
    assign idx      = addr[IDX_W-1:0];

    // Storage write.
    always_ff @(posedge clk) begin
        if (we && in_range) mem[idx] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata <= '0;
        else if (in_range) rdata <= mem[idx];
        else               rdata <= '0;
    end
endmodule

// File: rtl/acc_pair_alu.sv
// Combinational sign-magnitude arithmetic for the accumulator core.
// Gives next AC and MQ for the given opcode, using the memory operand md.
// Opcodes it does not handle pass AC and MQ through. Every result with
// zero magnitude is produced as +0.
module acc_pair_alu #(
    parameter int WORD_W = 40,
    parameter int OP_W   = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] mq,
    input  logic [WORD_W-1:0] md,
    output logic [WORD_W-1:0] ac_n,
    output logic [WORD_W-1:0] mq_n,
    output logic              div_zero
);
    import acc_pair_pkg::*;

    localparam int MAG_W  = WORD_W - 1;
    localparam int TC_W   = WORD_W + 1;
    localparam int PROD_W = 2 * MAG_W;

    function automatic logic [WORD_W-1:0] norm(input logic s, input logic [MAG_W-1:0] m);
        return {s && (m != '0), m};
    endfunction

    function automatic logic signed [TC_W-1:0] to_tc(input logic [WORD_W-1:0] w);
        logic signed [TC_W-1:0] v;
        v = $signed({2'b00, w[MAG_W-1:0]});
        return w[WORD_W-1] ? -v : v;
    endfunction

    function automatic logic [WORD_W-1:0] from_tc(input logic signed [TC_W-1:0] v);
        logic [TC_W-1:0] a;
        a = $unsigned(v[TC_W-1] ? -v : v);
        return norm(v[TC_W-1], a[MAG_W-1:0]);
    endfunction

    logic [MAG_W-1:0]  ac_mag, mq_mag, md_mag, dvs, quo, rem;
    logic [PROD_W-1:0] prod;
    logic              psign;

    assign ac_mag   = ac[MAG_W-1:0];
    assign mq_mag   = mq[MAG_W-1:0];
    assign md_mag   = md[MAG_W-1:0];
    assign div_zero = (md_mag == '0);
    assign dvs      = div_zero ? MAG_W'(1) : md_mag;
    assign quo      = ac_mag / dvs;
    assign rem      = ac_mag % dvs;
    assign prod     = PROD_W'(mq_mag) * PROD_W'(md_mag);
    assign psign    = mq[WORD_W-1] ^ md[WORD_W-1];

    // Opcode-selected result.
    always_comb begin
        ac_n = ac;
        mq_n = mq;
        case (op)
            OPC_LD:     ac_n = norm(md[WORD_W-1], md_mag);
            OPC_LDNEG:  ac_n = norm(!md[WORD_W-1], md_mag);
            OPC_LDABS:  ac_n = norm(1'b0, md_mag);
            OPC_LDNABS: ac_n = norm(1'b1, md_mag);
            OPC_ADD:    ac_n = from_tc(to_tc(ac) + to_tc(md));
            OPC_SUB:    ac_n = from_tc(to_tc(ac) - to_tc(md));
            OPC_ADDABS: ac_n = from_tc(to_tc(ac) + to_tc({1'b0, md_mag}));
            OPC_SUBABS: ac_n = from_tc(to_tc(ac) - to_tc({1'b0, md_mag}));
            OPC_LDMQ:   mq_n = norm(md[WORD_W-1], md_mag);
            OPC_MQ2AC:  ac_n = mq;
            OPC_MUL: begin
                ac_n = norm(psign, prod[PROD_W-1:MAG_W]);
                mq_n = norm(psign, prod[MAG_W-1:0]);
            end
            OPC_DIV: begin
                if (!div_zero) begin
                    mq_n = norm(ac[WORD_W-1] ^ md[WORD_W-1], quo);
                    ac_n = norm(ac[WORD_W-1], rem);
                end
            end
            OPC_SHL:    ac_n = norm(ac[WORD_W-1], {ac_mag[MAG_W-2:0], 1'b0});
            OPC_SHR:    ac_n = norm(ac[WORD_W-1], {1'b0, ac_mag[MAG_W-1:1]});
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_pair_cpu.sv
// Multi-cycle accumulator core with two instructions per memory word.
// Fetch captures a word in MBR and splits it: the left instruction goes to
// IR/MAR and the right one is buffered in IBR. Data reads pass through MBR
// before execution. The host port owns the memory only while the core is
// idle or halted. Assumes start is a pulse and the host stays quiet
// while the core runs.
module acc_pair_cpu
    import acc_pair_pkg::*;
#(
    parameter int MEM_DEPTH = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              halted,
    output logic              err_addr,
    output logic              err_div,
    output logic              err_ill,
    output logic [WORD_W-1:0] ac_out,
    output logic [WORD_W-1:0] mq_out
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_DEPTH);
    localparam int LA_HI = WORD_W - OP_W - 1;   // left address field top bit

    core_state_e       state;
    logic [ADDR_W-1:0] pc, mar;
    logic [WORD_W-1:0] mbr, ac, mq;
    logic [HALF_W-1:0] ibr;
    logic              ibr_v, skip_l;
    logic [OP_W-1:0]   ir;
    logic              running;
    logic              m_we;
    logic [ADDR_W-1:0] m_addr;
    logic [WORD_W-1:0] m_wdata, m_rdata;
    logic [WORD_W-1:0] alu_ac, alu_mq;
    logic              div_zero;

    assign running    = !(state == S_IDLE || state == S_HALT);
    assign host_rdata = m_rdata;
    assign ac_out     = ac;
    assign mq_out     = mq;

    acc_pair_mem #(.DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(m_we), .addr(m_addr),
        .wdata(m_wdata), .rdata(m_rdata)
    );

    acc_pair_alu #(.WORD_W(WORD_W), .OP_W(OP_W)) u_alu (
        .op(ir), .ac(ac), .mq(mq), .md(mbr),
        .ac_n(alu_ac), .mq_n(alu_mq), .div_zero(div_zero)
    );

    // Memory port owner: host when stopped, otherwise the sequencer.
    always_comb begin
        m_we    = host_we && !running;
        m_addr  = host_addr;
        m_wdata = host_wdata;
        if (running) begin
            m_we    = 1'b0;
            m_addr  = mar;
            m_wdata = ac;
            if (state == S_FETCH) m_addr = pc;
            if (state == S_DECODE && ir == OPC_ST && mar < LIMIT) m_we = 1'b1;
            if (state == S_EXEC && ir == OPC_STFL) begin
                m_we    = 1'b1;
                m_wdata = {mbr[WORD_W-1:LA_HI+1], ac[ADDR_W-1:0], mbr[HALF_W-1:0]};
            end
            if (state == S_EXEC && ir == OPC_STFR) begin
                m_we    = 1'b1;
                m_wdata = {mbr[WORD_W-1:ADDR_W], ac[ADDR_W-1:0]};
            end
        end
    end

    // Instruction sequencer and architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;  pc <= '0;  mar <= '0;  mbr <= '0;
            ac <= '0;  mq <= '0;  ibr <= '0;  ibr_v <= 1'b0;  skip_l <= 1'b0;
            ir <= '0;  halted <= 1'b0;
            err_addr <= 1'b0;  err_div <= 1'b0;  err_ill <= 1'b0;
        end else begin
            case (state)
                S_IDLE, S_HALT: if (start) begin
                    pc <= '0;  ibr_v <= 1'b0;  skip_l <= 1'b0;  halted <= 1'b0;
                    err_addr <= 1'b0;  err_div <= 1'b0;  err_ill <= 1'b0;
                    state <= S_FETCH;
                end
                S_FETCH: begin
                    if (pc >= LIMIT) begin
                        err_addr <= 1'b1;  halted <= 1'b1;  state <= S_HALT;
                    end else state <= S_FWAIT;
                end
                S_FWAIT: begin
                    mbr <= m_rdata;  pc <= pc + 1'b1;  state <= S_SPLIT;
                end
                S_SPLIT: begin
                    skip_l <= 1'b0;
                    if (skip_l) begin
                        ir <= mbr[HALF_W-1:ADDR_W];  mar <= mbr[ADDR_W-1:0];  ibr_v <= 1'b0;
                    end else begin
                        ir <= mbr[WORD_W-1:LA_HI+1];  mar <= mbr[LA_HI:HALF_W];
                        ibr <= mbr[HALF_W-1:0];  ibr_v <= 1'b1;
                    end
                    state <= S_DECODE;
                end
                S_DECODE: begin
                    if (!op_legal(ir)) begin
                        err_ill <= 1'b1;  halted <= 1'b1;  state <= S_HALT;
                    end else if (op_uses_mem(ir) && mar >= LIMIT) begin
                        err_addr <= 1'b1;  halted <= 1'b1;  state <= S_HALT;
                    end else begin
                        case (ir)
                            OPC_HALT: begin halted <= 1'b1; state <= S_HALT; end
                            OPC_MQ2AC, OPC_SHL, OPC_SHR: begin
                                ac <= alu_ac;  state <= S_NEXT;
                            end
                            OPC_JL, OPC_JR, OPC_JPL, OPC_JPR: begin
                                if ((ir == OPC_JL || ir == OPC_JR) || !ac[WORD_W-1]) begin
                                    pc <= mar;  ibr_v <= 1'b0;
                                    skip_l <= (ir == OPC_JR || ir == OPC_JPR);
                                    state <= S_FETCH;
                                end else state <= S_NEXT;
                            end
                            OPC_ST:  state <= S_NEXT;
                            default: state <= S_DWAIT;
                        endcase
                    end
                end
                S_DWAIT: begin
                    mbr <= m_rdata;  state <= S_EXEC;
                end
                S_EXEC: begin
                    if (ir == OPC_DIV && div_zero) begin
                        err_div <= 1'b1;  halted <= 1'b1;  state <= S_HALT;
                    end else begin
                        ac <= alu_ac;  mq <= alu_mq;  state <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (ibr_v) begin
                        ir <= ibr[HALF_W-1:ADDR_W];  mar <= ibr[ADDR_W-1:0];
                        ibr_v <= 1'b0;  state <= S_DECODE;
                    end else state <= S_FETCH;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: a halted core stays put until start.
    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> (halted && $stable(pc) && $stable(ac)));

    // R12: the core never writes memory at or beyond the limit.
    a_r12_no_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
        (running && m_we) |-> (m_addr < LIMIT));

    // R6: a zero divisor keeps AC and MQ and ends in the halted state.
    a_r6_divzero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && ir == OPC_DIV && div_zero) |=>
            ($stable(ac) && $stable(mq) && halted));

    // R13: at most one error is reported, and only while halted.
    a_r13_one_error: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_addr, err_div, err_ill}) && (!(err_addr || err_div || err_ill) || halted));

    // R2: the accumulator never holds a negative zero.
    a_r2_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(ac[WORD_W-1] && ac[WORD_W-2:0] == '0));
endmodule

// File: tb/acc_pair_cpu_bench.sv
// Bench for acc_pair_cpu. A behavioural interpreter of the instruction set
// runs each program beside the core. The final registers, flags and the
// whole memory are then compared.
module acc_pair_cpu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [39:0] host_wdata = '0;
    logic [39:0] host_rdata, ac_out, mq_out;
    logic        halted, err_addr, err_div, err_ill;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_pair_cpu u_acc_pair_cpu (
        .clk(clk), .rst_n(rst_n), .start(start), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .halted(halted), .err_addr(err_addr), .err_div(err_div), .err_ill(err_ill),
        .ac_out(ac_out), .mq_out(mq_out)
    );

    // reference state
    logic [39:0] mm [0:999];
    logic [39:0] mac = '0, mmq = '0;
    bit me_a, me_d, me_i;
    int m_pc;
    bit m_skip, m_done, m_jump;
    localparam longint MASK = (64'sd1 <<< 39) - 1;

    function automatic longint val(input logic [39:0] w);
        longint m;
        m = longint'({25'd0, w[38:0]});
        return w[39] ? -m : m;
    endfunction

    function automatic logic [39:0] mk(input longint v);
        longint a;
        a = (v < 0) ? -v : v;
        a = a & MASK;
        return {(v < 0) && (a != 0), a[38:0]};
    endfunction

    function automatic logic [39:0] mks(input logic s, input logic [38:0] m);
        return {s && (m != 0), m};
    endfunction

    function automatic logic [39:0] wd(input logic [7:0] o1, input int a1,
                                       input logic [7:0] o2, input int a2);
        return {o1, 12'(a1), o2, 12'(a2)};
    endfunction

    function automatic logic [39:0] sm(input bit s, input longint m);
        return {s, m[38:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic exec_one(input logic [19:0] ins);
        logic [7:0]  op;
        int          x;
        logic [39:0] d;
        logic [77:0] p;
        op = ins[19:12];
        x = int'(ins[11:0]);
        m_jump = 0;
        if (!(op <= 8'h10 || (op >= 8'h12 && op <= 8'h15) || op == 8'h21)) begin
            me_i = 1; m_done = 1; return;
        end
        if (!(op == 8'h00 || op == 8'h0A || op == 8'h14 || op == 8'h15) && x >= 1000) begin
            me_a = 1; m_done = 1; return;
        end
        d = (x < 1000) ? mm[x] : '0;
        case (op)
            8'h00: m_done = 1;
            8'h01: mac = mk(val(d));
            8'h02: mac = mk(-val(d));
            8'h03: mac = mk(val({1'b0, d[38:0]}));
            8'h04: mac = mk(-val({1'b0, d[38:0]}));
            8'h05: mac = mk(val(mac) + val(d));
            8'h06: mac = mk(val(mac) - val(d));
            8'h07: mac = mk(val(mac) + val({1'b0, d[38:0]}));
            8'h08: mac = mk(val(mac) - val({1'b0, d[38:0]}));
            8'h09: mmq = mk(val(d));
            8'h0A: mac = mmq;
            8'h0B: begin
                p = 78'(mmq[38:0]) * 78'(d[38:0]);
                mac = mks(mmq[39] ^ d[39], p[77:39]);
                mmq = mks(mmq[39] ^ d[39], p[38:0]);
            end
            8'h0C: begin
                if (d[38:0] == 0) begin me_d = 1; m_done = 1; end
                else begin
                    longint q, r;
                    q = longint'({25'd0, mac[38:0]}) / longint'({25'd0, d[38:0]});
                    r = longint'({25'd0, mac[38:0]}) % longint'({25'd0, d[38:0]});
                    mmq = mks(mac[39] ^ d[39], q[38:0]);
                    mac = mks(mac[39], r[38:0]);
                end
            end
            8'h0D, 8'h0E: begin m_pc = x; m_skip = (op == 8'h0E); m_jump = 1; end
            8'h0F, 8'h10: if (!mac[39]) begin m_pc = x; m_skip = (op == 8'h10); m_jump = 1; end
            8'h12: mm[x][31:20] = mac[11:0];
            8'h13: mm[x][11:0] = mac[11:0];
            8'h14: mac = mk(val(mac) * 2);
            8'h15: mac = mk(val(mac) / 2);
            8'h21: mm[x] = mac;
            default: ;
        endcase
    endtask

    task automatic model_run();
        int guard = 0;
        me_a = 0; me_d = 0; me_i = 0;
        m_pc = 0; m_skip = 0; m_done = 0;
        while (!m_done && guard < 5000) begin
            logic [39:0] w;
            int first;
            guard++;
            if (m_pc >= 1000) begin me_a = 1; m_done = 1; break; end
            w = mm[m_pc];
            m_pc++;
            first = m_skip ? 1 : 0;
            m_skip = 0;
            for (int h = first; h < 2; h++) begin
                exec_one(h == 0 ? w[39:20] : w[19:0]);
                if (m_done || m_jump) break;
            end
        end
    endtask

    task automatic host_wr(input int a, input logic [39:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 12'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        mm[a] = d;
    endtask

    task automatic clear_mem();
        @(negedge clk);
        host_we = 1'b1; host_wdata = '0;
        for (int i = 0; i < 1000; i++) begin
            host_addr = 12'(i);
            mm[i] = '0;
            @(negedge clk);
        end
        host_we = 1'b0;
    endtask

    task automatic run_and_compare(input string req);
        bit done_ok = 0;
        int bad = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R11", {req, " start clears halt/errors"},
              {36'd0, halted, err_addr, err_div, err_ill}, 40'd0);
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (halted) begin done_ok = 1; break; end
        end
        checks++;
        if (!done_ok) begin
            errors++;
            $display("FAIL %s watchdog: actual halted=0 expected halted=1", req);
        end
        model_run();
        check(req, "flags {addr,div,ill}", {37'd0, err_addr, err_div, err_ill},
              {37'd0, me_a, me_d, me_i});
        check(req, "AC", ac_out, mac);
        check(req, "MQ", mq_out, mmq);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk); host_addr = 12'(i);
            @(negedge clk);
            if (host_rdata !== mm[i]) begin
                if (bad == 0)
                    $display("FAIL %s/R14 word %0d: actual %h expected %h", req, i, host_rdata, mm[i]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run unfinished expected end of program list");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset flags", {36'd0, halted, err_addr, err_div, err_ill}, 40'd0);
        check("R1", "reset AC", ac_out, 40'd0);
        check("R1", "reset MQ", mq_out, 40'd0);

        // R3 R4 R2: loads, add/sub, overflow wrap, negative zero
        clear_mem();
        host_wr(0, wd(8'h01, 500, 8'h05, 501));
        host_wr(1, wd(8'h08, 502, 8'h21, 600));
        host_wr(2, wd(8'h02, 503, 8'h07, 502));
        host_wr(3, wd(8'h21, 601, 8'h04, 501));
        host_wr(4, wd(8'h06, 504, 8'h21, 602));
        host_wr(5, wd(8'h03, 503, 8'h06, 503));
        host_wr(6, wd(8'h21, 603, 8'h01, 505));
        host_wr(7, wd(8'h21, 604, 8'h05, 506));
        host_wr(8, wd(8'h05, 506, 8'h21, 605));
        host_wr(500, sm(0, 100));
        host_wr(501, sm(1, 30));
        host_wr(502, sm(1, 7));
        host_wr(503, sm(0, 55));
        host_wr(504, sm(1, 64'sd1 <<< 38));
        host_wr(505, sm(1, 0));
        host_wr(506, sm(0, MASK));
        run_and_compare("R3/R4/R2");

        // R5 R6 R3: multiply, divide, MQ moves
        clear_mem();
        host_wr(0, wd(8'h09, 500, 8'h0B, 501));
        host_wr(1, wd(8'h21, 600, 8'h0A, 0));
        host_wr(2, wd(8'h21, 601, 8'h01, 502));
        host_wr(3, wd(8'h0C, 503, 8'h21, 602));
        host_wr(4, wd(8'h0A, 0, 8'h21, 603));
        host_wr(5, wd(8'h02, 502, 8'h0C, 504));
        host_wr(6, wd(8'h21, 604, 8'h0A, 0));
        host_wr(7, wd(8'h21, 605, 8'h00, 0));
        host_wr(500, sm(1, 123456789));
        host_wr(501, sm(0, 987654321));
        host_wr(502, sm(0, 1000003));
        host_wr(503, sm(1, 17));
        host_wr(504, sm(0, 7));
        run_and_compare("R5/R6/R3");

        // R7 R8 R1: jumps to both halves, conditional taken and not taken
        clear_mem();
        host_wr(0, wd(8'h01, 500, 8'h0E, 3));
        host_wr(1, wd(8'h01, 501, 8'h21, 601));
        host_wr(3, wd(8'h01, 502, 8'h0F, 5));
        host_wr(4, wd(8'h21, 602, 8'h00, 0));
        host_wr(5, wd(8'h21, 600, 8'h01, 503));
        host_wr(6, wd(8'h10, 9, 8'h21, 603));
        host_wr(7, wd(8'h02, 503, 8'h10, 8));
        host_wr(8, wd(8'h21, 604, 8'h0D, 10));
        host_wr(9, wd(8'h21, 605, 8'h00, 0));
        host_wr(10, wd(8'h21, 606, 8'h00, 0));
        host_wr(500, sm(0, 5));
        host_wr(501, sm(0, 11));
        host_wr(502, sm(0, 22));
        host_wr(503, sm(1, 9));
        run_and_compare("R7/R8/R1");

        // R9 R10: partial stores and shifts with ignored address fields
        clear_mem();
        host_wr(0, wd(8'h01, 502, 8'h12, 500));
        host_wr(1, wd(8'h13, 501, 8'h14, 4000));
        host_wr(2, wd(8'h21, 600, 8'h15, 4095));
        host_wr(3, wd(8'h15, 0, 8'h21, 601));
        host_wr(4, wd(8'h01, 503, 8'h14, 12));
        host_wr(5, wd(8'h21, 602, 8'h01, 504));
        host_wr(6, wd(8'h15, 0, 8'h21, 603));
        host_wr(500, 40'hA5A5A5A5A5);
        host_wr(501, 40'h123456789A);
        host_wr(502, 40'h0011223FED);
        host_wr(503, sm(1, (64'sd1 <<< 38) + 3));
        host_wr(504, sm(1, 1));
        run_and_compare("R9/R10");

        // R6: divide by negative zero keeps AC and MQ
        clear_mem();
        host_wr(0, wd(8'h01, 500, 8'h09, 501));
        host_wr(1, wd(8'h0C, 502, 8'h21, 600));
        host_wr(500, sm(1, 4242));
        host_wr(501, sm(0, 77));
        host_wr(502, sm(1, 0));
        run_and_compare("R6");

        // R12: store to address 1000
        clear_mem();
        host_wr(0, wd(8'h01, 500, 8'h21, 1000));
        host_wr(500, sm(0, 31));
        run_and_compare("R12");

        // R12: running off the end of memory
        clear_mem();
        host_wr(0, wd(8'h0D, 999, 8'h00, 0));
        host_wr(999, wd(8'h01, 500, 8'h05, 500));
        host_wr(500, sm(1, 3));
        run_and_compare("R12");

        // R13: undefined opcode
        clear_mem();
        host_wr(0, wd(8'h01, 500, 8'h11, 0));
        host_wr(1, wd(8'h21, 600, 8'h00, 0));
        host_wr(500, sm(0, 8));
        run_and_compare("R13");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule